// File: doc/BRIEF.md
# DMA Channel Interrupt Coalescing Controller

This block keeps the control and status registers of one DMA channel and generates that channel's interrupt. Software reaches four 32-bit registers over a simple register bus: control, status, current-descriptor pointer and tail-descriptor pointer. The data mover sends the block a one-cycle pulse each time a transfer completes. It can also report that it has gone idle.

Interrupts are coalesced in two ways. A completion counter counts down from a programmable threshold and flags an interrupt when it reaches zero. A delay timer restarts on every completion and flags a second interrupt once completions stop for long enough. Both live counts can be read back through the status register. The interrupt line is high when a pending flag has its enable set. The block also drives the run request, a soft-reset request and a start pulse to the data mover.

Top module: `dma_irq_coalesce`

## Requirements
- R1: After reset, control reads 0x00010002 and status reads 0x00010001. This is halted, with a completion count of 1. `irq_o`, `run_o`, `soft_rst_o` and `start_o` are low.
- R2: Control word offset 0x00 holds:
  - bit 0: run
  - bit 1: always reads 1
  - bit 2: soft-reset command, always reads 0
  - bits [14:12]: interrupt enables
  - bits [23:16]: completion threshold
  - bits [31:24]: delay timeout
  
  All other bits read back as written.
- R3: Status word offset 0x04 holds:
  - bit 0: halted
  - bit 1: idle
  - bits [14:12]: interrupt flags (12 is completion, 13 is delay)
  - bits [23:16]: live completion count
  - bits [31:24]: live delay count
  
  A control write with bit 0 = 1 and bit 2 = 0, made while no soft reset is pending, clears halted and idle. `run_o` is the run bit ANDed with not-halted.
- R4: A control write with bit 2 set does the following:
  - loads the reset control value
  - sets halted
  - clears idle and the flags
  - stops the delay timer
  - raises `soft_rst_o`
  
  `soft_rst_o` stays high until the next control read. While it is high, a run write leaves halted set.
- R5: Each completion pulse decrements the completion count. A decrement from 1 sets flag 12 and reloads the count from the threshold. A threshold of 0 therefore gives one flag per 256 completions.
- R6: Every control write reloads the completion count from the threshold field of the value being written.
- R7: A completion with a nonzero delay field loads the delay count with that field. The count then falls by one every PRESCALE clocks. When it reaches zero, D×PRESCALE clocks after the last completion edge, flag 13 is set and the completion count reloads. A completion with a delay field of 0 does not load the timer.
- R8: `irq_o` is high exactly when some status bit in [14:12] has the matching control enable bit set.
- R9: Writing 1 to a status flag bit clears it, and writing 0 leaves it unchanged. If hardware sets a flag in the same cycle as the clearing write, the flag stays set.
- R10: A write to the tail pointer (0x10) stores the value and clears idle. It also makes `start_o` high for exactly the one cycle after the write edge. `idle_set_i` sets idle.
- R11: The current-descriptor pointer (0x08) and the tail pointer read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (for read side effects) |
| reg_addr_i | input | AW | Byte offset within the channel |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| cmpl_i | input | 1 | One-cycle completion pulse from the data mover |
| idle_set_i | input | 1 | Data mover reports that it reached the tail |
| irq_o | output | 1 | Channel interrupt |
| run_o | output | 1 | Run request to the data mover |
| soft_rst_o | output | 1 | Soft-reset request, pending until control is read |
| start_o | output | 1 | One-cycle start pulse after a tail-pointer write |
| halted_o | output | 1 | Halted status |
| idle_o | output | 1 | Idle status |

## Verification
The hardest case to reach is a delay expiry measured to the exact clock. This matters most when the timer is restarted partway through its count, and when a hardware flag set lands in the same cycle as a write-1-to-clear.

The bench sweeps the delay field and counts clocks from the completion edge to the first cycle the delay flag is seen. It fires a second completion before the first countdown finishes and measures again from that second completion. It drives a completion together with a clearing status write in one cycle, with the counter at 1.

Threshold sweeps, including a threshold of 0, check the count at every step against simple arithmetic.

// File: rtl/dma_coal_pkg.sv
package dma_coal_pkg;
  localparam int DW    = 32;
  localparam int CNT_W = 8;

  localparam int WIDX_CTRL = 0;
  localparam int WIDX_STAT = 1;
  localparam int WIDX_CUR  = 2;
  localparam int WIDX_TAIL = 4;

  localparam int BIT_RUN   = 0;
  localparam int BIT_SRST  = 2;
  localparam int IRQ_LSB   = 12;
  localparam int IRQ_W     = 3;
  localparam int THR_LSB   = 16;
  localparam int DLY_LSB   = 24;

  localparam logic [DW-1:0] CTRL_RST = 32'h0001_0002;
endpackage

// File: rtl/dma_coal_cnt.sv
module dma_coal_cnt #(
  parameter int W       = 8,
  parameter int RST_VAL = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] thr_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = dec_i & ~load_i & (cnt_q == W'(1));
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= W'(RST_VAL);
    else if (load_i)    cnt_q <= thr_i;
    else if (dec_i)     cnt_q <= (cnt_q == W'(1)) ? thr_i : cnt_q - W'(1);
  end
endmodule

// File: rtl/dma_coal_dly.sv
module dma_coal_dly #(
  parameter int W        = 8,
  parameter int PRESCALE = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [W-1:0] cnt_q;
  logic         armed, tick, active;

  assign armed    = load_i & (val_i != '0);
  assign active   = (cnt_q != '0);
  assign expire_o = ~clr_i & ~armed & (cnt_q == W'(1)) & tick;
  assign cnt_o    = cnt_q;

  generate
    if (PRESCALE > 1) begin : g_div
      logic [PW-1:0] pre_q;
      assign tick = (pre_q == PW'(PRESCALE - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          pre_q <= '0;
        else if (clr_i || armed || !active)   pre_q <= '0;
        else if (tick)                        pre_q <= '0;
        else                                  pre_q <= pre_q + PW'(1);
      end
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (armed)           cnt_q <= val_i;
    else if (active && tick)  cnt_q <= cnt_q - W'(1);
  end
endmodule

// File: rtl/dma_irq_coalesce.sv
module dma_irq_coalesce
  import dma_coal_pkg::*;
#(
  parameter int AW       = 6,
  parameter int PRESCALE = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          cmpl_i,
  input  logic          idle_set_i,
  output logic          irq_o,
  output logic          run_o,
  output logic          soft_rst_o,
  output logic          start_o,
  output logic          halted_o,
  output logic          idle_o
);
  localparam int IW = AW - 2;

  logic [IW-1:0]    widx;
  logic             aligned;
  logic             sel_ctrl, sel_stat, sel_cur, sel_tail;
  logic             ctrl_we, ctrl_re, stat_we, cur_we, tail_we;
  logic             soft_rst, run_go;
  logic [DW-1:0]    ctrl_q, ctrl_d, cur_q, tail_q;
  logic             halted_q, idle_q, rst_pend_q, start_q;
  logic [IRQ_W-1:0] flag_q, flag_set, flag_clr;
  logic [CNT_W-1:0] cnt_q, dly_cnt, dly_cfg;
  logic             cnt_hit, dly_expire;

  assign widx     = reg_addr_i[AW-1:2];
  assign aligned  = (reg_addr_i[1:0] == 2'b00);
  assign sel_ctrl = aligned & (widx == IW'(WIDX_CTRL));
  assign sel_stat = aligned & (widx == IW'(WIDX_STAT));
  assign sel_cur  = aligned & (widx == IW'(WIDX_CUR));
  assign sel_tail = aligned & (widx == IW'(WIDX_TAIL));

  assign ctrl_we  = reg_we_i & sel_ctrl;
  assign ctrl_re  = reg_re_i & sel_ctrl;
  assign stat_we  = reg_we_i & sel_stat;
  assign cur_we   = reg_we_i & sel_cur;
  assign tail_we  = reg_we_i & sel_tail;

  assign soft_rst = ctrl_we & reg_wdata_i[BIT_SRST];
  assign run_go   = ctrl_we & reg_wdata_i[BIT_RUN] & ~reg_wdata_i[BIT_SRST] & ~rst_pend_q;

  // bit 2 is never stored, bit 1 is forced
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we)
      ctrl_d = soft_rst ? CTRL_RST : {reg_wdata_i[DW-1:3], 2'b01, reg_wdata_i[BIT_RUN]};
  end

  assign dly_cfg  = ctrl_q[DLY_LSB +: CNT_W];
  assign flag_set = {1'b0, dly_expire, cnt_hit};
  assign flag_clr = stat_we ? reg_wdata_i[IRQ_LSB +: IRQ_W] : '0;

  dma_coal_cnt #(.W(CNT_W), .RST_VAL(1)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ctrl_we | dly_expire),
    .thr_i  (ctrl_d[THR_LSB +: CNT_W]),
    .dec_i  (cmpl_i),
    .cnt_o  (cnt_q),
    .hit_o  (cnt_hit)
  );

  dma_coal_dly #(.W(CNT_W), .PRESCALE(PRESCALE)) u_dly (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (soft_rst),
    .load_i   (cmpl_i),
    .val_i    (dly_cfg),
    .cnt_o    (dly_cnt),
    .expire_o (dly_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= CTRL_RST;
      cur_q      <= '0;
      tail_q     <= '0;
      halted_q   <= 1'b1;
      idle_q     <= 1'b0;
      rst_pend_q <= 1'b0;
      start_q    <= 1'b0;
      flag_q     <= '0;
    end else begin
      ctrl_q     <= ctrl_d;
      if (cur_we)  cur_q  <= reg_wdata_i;
      if (tail_we) tail_q <= reg_wdata_i;
      start_q    <= tail_we;
      rst_pend_q <= soft_rst | (rst_pend_q & ~ctrl_re);
      halted_q   <= soft_rst | (halted_q & ~run_go);
      idle_q     <= ~soft_rst & ~run_go & ~tail_we & (idle_q | idle_set_i);
      // hardware set beats the clearing write
      flag_q     <= soft_rst ? '0 : ((flag_q & ~flag_clr) | flag_set);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (sel_ctrl)      reg_rdata_o = ctrl_q;
    else if (sel_stat) reg_rdata_o = {dly_cnt, cnt_q, 1'b0, flag_q, 10'b0, idle_q, halted_q};
    else if (sel_cur)  reg_rdata_o = cur_q;
    else if (sel_tail) reg_rdata_o = tail_q;
  end

  assign irq_o      = |(flag_q & ctrl_q[IRQ_LSB +: IRQ_W]);
  assign run_o      = ctrl_q[BIT_RUN] & ~halted_q;
  assign soft_rst_o = rst_pend_q;
  assign start_o    = start_q;
  assign halted_o   = halted_q;
  assign idle_o     = idle_q;
endmodule

// File: rtl/dma_irq_coalesce_chk.sv
module dma_irq_coalesce_chk #(
  parameter int AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [31:0]   reg_wdata_i,
  input logic          cmpl_i,
  input logic          start_o,
  input logic          halted_q,
  input logic          rst_pend_q,
  input logic [7:0]    cnt_q,
  input logic [7:0]    dly_cnt,
  input logic [7:0]    dly_cfg
);
  logic wr_ctrl, wr_tail;
  assign wr_ctrl = reg_we_i && (reg_addr_i == AW'(0));
  assign wr_tail = reg_we_i && (reg_addr_i == AW'(16));

  assert_tail_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tail |=> start_o);

  assert_start_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !wr_tail) |=> !start_o);

  assert_ctrl_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !reg_wdata_i[2]) |=> (cnt_q == $past(reg_wdata_i[23:16])));

  assert_soft_halt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && reg_wdata_i[2]) |=> (halted_q && rst_pend_q));

  assert_run_clears_halt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && reg_wdata_i[0] && !reg_wdata_i[2] && !rst_pend_q) |=> !halted_q);

  assert_dly_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && (dly_cfg != 8'd0) && !reg_we_i) |=> (dly_cnt == $past(dly_cfg)));
endmodule

bind dma_irq_coalesce dma_irq_coalesce_chk #(.AW(AW)) u_chk (.*);

// File: tb/dma_irq_coalesce_test.sv
`timescale 1ns/1ps
module dma_irq_coalesce_test;
  localparam int AW  = 6;
  localparam int PRE = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [AW-1:0] reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          cmpl_i = 1'b0, idle_set_i = 1'b0;
  logic          irq_o, run_o, soft_rst_o, start_o, halted_o, idle_o;

  int n_chk = 0, n_bad = 0;

  always #2 clk_i = ~clk_i;

  dma_irq_coalesce #(.AW(AW), .PRESCALE(PRE)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic cmpl();
    @(negedge clk_i); cmpl_i = 1'b1;
    @(negedge clk_i); cmpl_i = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int hit_at;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    peek(6'h00, v); check("R1 ctrl", v, 32'h0001_0002);
    peek(6'h04, v); check("R1 status", v, 32'h0001_0001);
    check("R1 outs", {28'd0, irq_o, run_o, soft_rst_o, start_o}, 32'd0);

    // R2 control readback
    wr(6'h00, 32'hFFFF_FFF8); rd(6'h00, v); check("R2 ones", v, 32'hFFFF_FFFA);
    wr(6'h00, 32'h0000_0000); rd(6'h00, v); check("R2 zero", v, 32'h0000_0002);

    // R11 pointers
    wr(6'h08, 32'hDEAD_BEEF); rd(6'h08, v); check("R11 cur", v, 32'hDEAD_BEEF);

    // R3 run start, R10 idle / tail / start pulse
    wr(6'h00, 32'h0001_0001);
    peek(6'h04, v); check("R3 halt/idle clear", v[1:0], 32'd0);
    check("R3 run_o", {31'd0, run_o}, 32'd1);
    @(negedge clk_i); idle_set_i = 1'b1; @(negedge clk_i); idle_set_i = 1'b0;
    peek(6'h04, v); check("R10 idle set", v[1:0], 32'd2);
    wr(6'h10, 32'h0000_1240);
    check("R10 start high", {31'd0, start_o}, 32'd1);
    peek(6'h04, v); check("R10 idle cleared", v[1:0], 32'd0);
    @(negedge clk_i); check("R10 start one cycle", {31'd0, start_o}, 32'd0);
    rd(6'h10, v); check("R11 tail", v, 32'h0000_1240);

    // R4 soft reset
    wr(6'h00, 32'h0000_0005);
    check("R4 soft_rst_o", {31'd0, soft_rst_o}, 32'd1);
    peek(6'h04, v); check("R4 status halted", v, 32'h0001_0001);
    wr(6'h00, 32'h0001_0001);
    peek(6'h04, v); check("R4 run blocked", v[0], 32'd1);
    check("R4 run_o low", {31'd0, run_o}, 32'd0);
    rd(6'h00, v); check("R4 ctrl bit2 reads 0", v, 32'h0001_0003);
    check("R4 pending cleared", {31'd0, soft_rst_o}, 32'd0);
    wr(6'h00, 32'h0001_0001);
    peek(6'h04, v); check("R4 run after read", v[0], 32'd0);

    // R8 enable gating
    wr(6'h04, 32'h0000_7000);
    cmpl();
    peek(6'h04, v); check("R8 flag pending", v[12], 32'd1);
    check("R8 masked", {31'd0, irq_o}, 32'd0);
    wr(6'h00, 32'h0001_1001);
    check("R8 enabled", {31'd0, irq_o}, 32'd1);
    wr(6'h04, 32'h0000_1000);
    check("R9 w1c clears", {31'd0, irq_o}, 32'd0);

    // R5 threshold sweep
    for (int t = 1; t <= 6; t++) begin
      wr(6'h04, 32'h0000_7000);
      wr(6'h00, (t << 16) | 32'h0000_1001);
      peek(6'h04, v); check("R6 reload on write", v[23:16], t);
      for (int k = 1; k < t; k++) cmpl();
      peek(6'h04, v); check("R5 count before", v[23:16], 32'd1);
      check("R5 no irq before", {31'd0, irq_o}, 32'd0);
      cmpl();
      check("R5 irq at threshold", {31'd0, irq_o}, 32'd1);
      peek(6'h04, v); check("R5 reloaded", v[23:16], t);
    end
    // threshold 0 acts as 256
    wr(6'h04, 32'h0000_7000);
    wr(6'h00, 32'h0000_1001);
    for (int k = 0; k < 255; k++) cmpl();
    peek(6'h04, v); check("R5 thr0 count", v[23:16], 32'd1);
    check("R5 thr0 no irq", {31'd0, irq_o}, 32'd0);
    cmpl();
    check("R5 thr0 irq", {31'd0, irq_o}, 32'd1);

    // R9 set beats clear in the same cycle
    wr(6'h00, 32'h0001_1001);
    wr(6'h04, 32'h0000_7000);
    @(negedge clk_i);
    cmpl_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 6'h04; reg_wdata_i = 32'h0000_1000;
    @(negedge clk_i);
    cmpl_i = 1'b0; reg_we_i = 1'b0;
    peek(6'h04, v); check("R9 set wins", v[12], 32'd1);

    // R7 delay sweep
    for (int d = 1; d <= 5; d++) begin
      wr(6'h00, (d << 24) | 32'h0008_2001);
      wr(6'h04, 32'h0000_7000);
      cmpl();
      peek(6'h04, v);
      check("R7 loaded", v[31:24], d);
      check("R7 count after cmpl", v[23:16], 32'd7);
      hit_at = -1;
      for (int j = 1; j <= 100; j++) begin
        @(negedge clk_i); peek(6'h04, v);
        if (v[13]) begin hit_at = j; break; end
      end
      check("R7 expiry cycle", hit_at, d * PRE);
      check("R7 irq", {31'd0, irq_o}, 32'd1);
      check("R7 count reload", v[23:16], 32'd8);
    end
    // restart on a second completion
    wr(6'h00, 32'h0308_2001);
    wr(6'h04, 32'h0000_7000);
    cmpl();
    repeat (5) @(negedge clk_i);
    peek(6'h04, v); check("R7 not yet", v[13], 32'd0);
    cmpl();
    hit_at = -1;
    for (int j = 1; j <= 100; j++) begin
      @(negedge clk_i); peek(6'h04, v);
      if (v[13]) begin hit_at = j; break; end
    end
    check("R7 restart expiry", hit_at, 3 * PRE);
    // zero delay field leaves the timer stopped
    wr(6'h00, 32'h0008_2001);
    wr(6'h04, 32'h0000_7000);
    cmpl();
    repeat (40) @(negedge clk_i);
    peek(6'h04, v);
    check("R7 zero delay no flag", v[13], 32'd0);
    check("R7 zero delay count", v[31:24], 32'd0);

    summary();
    $finish;
  end
endmodule